// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one chip-select rank of DDR2 memory from power-up to operation. A single-cycle start pulse makes it sample its configuration inputs. It then drives a fixed series of commands onto a strobed command port. The mode-register value bus carries the word each mode or extended-mode load needs. It builds that word from the CAS latency, the write-recovery setting and the channel width. Two fixed waits sit in the series. Their length in clock cycles comes from the PLL divider input, and the waits give the DRAM the settle time it needs after power-down release and after the DLL reset.

The chip-select field goes out with every command. It is the rank mask. In large-memory mode a two-bit rank qualifier is also merged into field bits 3:2, so that every bank receives the precharge. When the last command has been issued, a done flag pulses once and the block returns to idle. A start pulse that arrives while a series is running is ignored.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: Command strobes appear in exactly this order: clear power-down, precharge-all, extended-mode load, mode load, precharge-all, auto-refresh, auto-refresh, mode load, extended-mode load, extended-mode load. `cmd_op` encodings are 1 clear power-down, 2 precharge-all, 3 extended-mode load, 4 mode load, 5 auto-refresh, and 0 whenever `cmd_valid` is low.
- R2: A wait of W cycles follows clear power-down and also follows the first mode load, so the next strobe comes W+2 cycles after the previous one. W = 400000 / (100 * d / 2) in integer arithmetic, with a reference clock of 100 MHz. d is `pll_div`, except that d = 6 when `pll_div` is 0. W is at least 1.
- R3: At most one strobe is issued per cycle, and two strobes are never in adjacent cycles. The first strobe comes 2 cycles after the cycle in which start is sampled. Consecutive commands with no wait between them come 2 cycles apart.
- R4: The first mode load has bit 8 (DLL reset) set. The second mode load, the one after the two auto-refreshes, has bit 8 clear. All other bits of the two words are equal, and bits 3, 7 and 12 are 0.
- R5: In order, the three extended-mode loads carry 0x400, 0x780 and 0x400. Bit 10 is differential-strobe disable, bit 0 = 0 enables the DLL, and bits 9:7 are the output-driver calibration field.
- R6: Mode-word bits 6:4 carry the CAS latency. A `cas_sel` value of 2, 3 or 4 is used as given, and any other value gives 3.
- R7: Mode-word bits 2:0 carry the burst length. It is 3'b010 (burst 4) when `wide_chan` is 1 and 3'b011 (burst 8) when `wide_chan` is 0.
- R8: Mode-word bits 11:9 carry the write recovery. `wr_sel` 4 gives 3'b011, 3 gives 3'b010, and any other value gives 3'b001.
- R9: `cs_field` at every strobe equals `cs_mask`, OR'd with `rank_qual` shifted to bits 3:2 when `big_mem` is 1. It is held through the whole series.
- R10: `mode_val` during a mode or extended-mode strobe equals its value in the preceding cycle.
- R11: `done` is high for exactly one cycle, the cycle after the last strobe, and the block is then idle. Start pulses and input changes during a running series have no effect on it.
- R12: While `rst` is high and in the first cycle after it, `cmd_valid` and `done` are 0. A reset in the middle of a series ends that series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a series when idle |
| cs_mask | input | CS_W | Rank chip-select mask |
| rank_qual | input | 2 | Rank qualifier for large-memory mode |
| big_mem | input | 1 | Merge rank qualifier into bits 3:2 |
| cas_sel | input | 3 | Requested CAS latency |
| wr_sel | input | 3 | Requested write recovery |
| wide_chan | input | 1 | 1 = 64-bit channel, 0 = 32-bit channel |
| pll_div | input | PLL_W | PLL divider, sets the wait length |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 3 | Command opcode |
| mode_val | output | 13 | Mode or extended-mode word |
| cs_field | output | CS_W | Chip-select field |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to reach from the ports are a start pulse that lands inside a running series and a reset partway through one. The ignored start also carries a different mask and divider, so the old series would show the difference if the pulse were taken. The stimulus pulses start with changed inputs during the first wait. It then checks that the strobes, the spacing and the mask still match the original request, and that no second series follows done. A reset is also asserted during the first wait. After it, the bench checks that no stale strobe appears and that a fresh series runs cleanly. Divider 0 and several odd and even dividers exercise the wait arithmetic.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int MODE_W     = 13;
    localparam int STEP_W     = 4;
    localparam int STEP_COUNT = 12;

    // mode-word field positions (decoded by the DRAM)
    localparam int MR_BL_LSB  = 0;
    localparam int MR_CAS_LSB = 4;
    localparam int MR_WR_LSB  = 9;
    localparam int MR_DLL_BIT = 8;

    localparam logic [MODE_W-1:0] MR_DLL_RST_MASK = MODE_W'(1) << MR_DLL_BIT;
    localparam logic [MODE_W-1:0] EMR_BASE_VAL    = 13'h0400;
    localparam logic [MODE_W-1:0] EMR_OCD_VAL     = EMR_BASE_VAL | 13'h0380;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_CLR_PD  = 3'd1,
        OP_PRE_ALL = 3'd2,
        OP_EMRS    = 3'd3,
        OP_MRS     = 3'd4,
        OP_AREF    = 3'd5
    } ddr2_op_e;

    typedef enum logic [2:0] {
        MSEL_NONE      = 3'd0,
        MSEL_MR_DLLRST = 3'd1,
        MSEL_MR_RUN    = 3'd2,
        MSEL_EMR_BASE  = 3'd3,
        MSEL_EMR_OCD   = 3'd4
    } msel_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    typedef struct packed {
        ddr2_op_e op;
        logic     is_wait;
        msel_e    msel;
    } step_t;

endpackage

// File: rtl/ddr2_step_table.sv
module ddr2_step_table
    import ddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             entry
);

    always_comb begin
        entry = '{op: OP_NOP, is_wait: 1'b0, msel: MSEL_NONE};
        case (idx)
            4'd0:  entry = '{op: OP_CLR_PD,  is_wait: 1'b0, msel: MSEL_NONE};
            4'd1:  entry = '{op: OP_NOP,     is_wait: 1'b1, msel: MSEL_NONE};
            4'd2:  entry = '{op: OP_PRE_ALL, is_wait: 1'b0, msel: MSEL_NONE};
            4'd3:  entry = '{op: OP_EMRS,    is_wait: 1'b0, msel: MSEL_EMR_BASE};
            4'd4:  entry = '{op: OP_MRS,     is_wait: 1'b0, msel: MSEL_MR_DLLRST};
            4'd5:  entry = '{op: OP_NOP,     is_wait: 1'b1, msel: MSEL_NONE};
            4'd6:  entry = '{op: OP_PRE_ALL, is_wait: 1'b0, msel: MSEL_NONE};
            4'd7:  entry = '{op: OP_AREF,    is_wait: 1'b0, msel: MSEL_NONE};
            4'd8:  entry = '{op: OP_AREF,    is_wait: 1'b0, msel: MSEL_NONE};
            4'd9:  entry = '{op: OP_MRS,     is_wait: 1'b0, msel: MSEL_MR_RUN};
            4'd10: entry = '{op: OP_EMRS,    is_wait: 1'b0, msel: MSEL_EMR_OCD};
            4'd11: entry = '{op: OP_EMRS,    is_wait: 1'b0, msel: MSEL_EMR_BASE};
            default: entry = '{op: OP_NOP,   is_wait: 1'b0, msel: MSEL_NONE};
        endcase
    end

endmodule

// File: rtl/ddr2_mode_build.sv
module ddr2_mode_build
    import ddr2_init_pkg::*;
(
    input  logic [2:0]        cas_sel,
    input  logic [2:0]        wr_sel,
    input  logic              wide_chan,
    output logic [MODE_W-1:0] mr_base
);

    logic [2:0] cas_code;
    logic [2:0] bl_code;
    logic [2:0] wr_code;

    always_comb begin
        case (cas_sel)
            3'd2, 3'd3, 3'd4: cas_code = cas_sel;
            default:          cas_code = 3'd3;
        endcase

        bl_code = wide_chan ? 3'b010 : 3'b011;

        case (wr_sel)
            3'd4:    wr_code = 3'b011;
            3'd3:    wr_code = 3'b010;
            default: wr_code = 3'b001;
        endcase

        mr_base = '0;
        mr_base[MR_BL_LSB  +: 3] = bl_code;
        mr_base[MR_CAS_LSB +: 3] = cas_code;
        mr_base[MR_WR_LSB  +: 3] = wr_code;
    end

endmodule

// File: rtl/ddr2_wait_calc.sv
module ddr2_wait_calc #(
    parameter int PLL_W      = 5,
    parameter int REFCLK_MHZ = 100,
    parameter int DLY_NS     = 400,
    parameter int CNT_W      = 19
) (
    input  logic [PLL_W-1:0] pll_div,
    output logic [CNT_W-1:0] wait_len
);

    localparam int NUMER = DLY_NS * 1000;

    logic [31:0]      eff_div;
    logic [31:0]      denom;
    logic [CNT_W-1:0] quot;

    always_comb begin
        eff_div = (pll_div == '0) ? 32'd6 : 32'(pll_div);
        denom   = (32'(REFCLK_MHZ) * eff_div) >> 1;
        if (denom == 32'd0) begin
            denom = 32'd1;
        end
        quot = CNT_W'(32'(NUMER) / denom);
        if (quot == '0) begin
            quot = CNT_W'(1);
        end
        wait_len = quot;
    end

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
    import ddr2_init_pkg::*;
#(
    parameter int CS_W       = 4,
    parameter int PLL_W      = 5,
    parameter int REFCLK_MHZ = 100,
    parameter int DLY_NS     = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CS_W-1:0]   cs_mask,
    input  logic [1:0]        rank_qual,
    input  logic              big_mem,
    input  logic [2:0]        cas_sel,
    input  logic [2:0]        wr_sel,
    input  logic              wide_chan,
    input  logic [PLL_W-1:0]  pll_div,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [MODE_W-1:0] mode_val,
    output logic [CS_W-1:0]   cs_field,
    output logic              done
);

    localparam int CNT_W    = $clog2(DLY_NS * 1000 + 1);
    localparam int QUAL_LSB = 2;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  wlen;
        logic [MODE_W-1:0] mr;
        logic [CS_W-1:0]   cs;
        logic              vld;
        logic [2:0]        op;
        logic [MODE_W-1:0] mode;
        logic              done;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    logic [CS_W-1:0]   cs_in;
    logic [MODE_W-1:0] mr_base;
    logic [CNT_W-1:0]  wait_len;
    logic [STEP_W-1:0] look_idx;
    step_t             look;

    // chip-select merge: qualifier lands on bits QUAL_LSB+1:QUAL_LSB
    for (genvar gi = 0; gi < CS_W; gi++) begin : g_cs
        if (gi >= QUAL_LSB && gi < QUAL_LSB + 2) begin : g_qual
            assign cs_in[gi] = cs_mask[gi] | (big_mem & rank_qual[gi-QUAL_LSB]);
        end else begin : g_plain
            assign cs_in[gi] = cs_mask[gi];
        end
    end

    ddr2_mode_build u_mode (
        .cas_sel   (cas_sel),
        .wr_sel    (wr_sel),
        .wide_chan (wide_chan),
        .mr_base   (mr_base)
    );

    ddr2_wait_calc #(
        .PLL_W      (PLL_W),
        .REFCLK_MHZ (REFCLK_MHZ),
        .DLY_NS     (DLY_NS),
        .CNT_W      (CNT_W)
    ) u_wait (
        .pll_div  (pll_div),
        .wait_len (wait_len)
    );

    // in ISSUE/WAIT look ahead at the following step, otherwise current
    assign look_idx = (s_q.st == ST_ISSUE || s_q.st == ST_WAIT)
                    ? STEP_W'(s_q.step + 1'b1) : s_q.step;

    ddr2_step_table u_table (
        .idx   (look_idx),
        .entry (look)
    );

    function automatic logic [MODE_W-1:0] pick_mode(
        input msel_e             sel,
        input logic [MODE_W-1:0] mr,
        input logic [MODE_W-1:0] hold
    );
        logic [MODE_W-1:0] r;
        case (sel)
            MSEL_MR_DLLRST: r = mr | MR_DLL_RST_MASK;
            MSEL_MR_RUN:    r = mr & ~MR_DLL_RST_MASK;
            MSEL_EMR_BASE:  r = EMR_BASE_VAL;
            MSEL_EMR_OCD:   r = EMR_OCD_VAL;
            default:        r = hold;
        endcase
        return r;
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.op   = OP_NOP;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_GAP;
                    s_d.step = '0;
                    s_d.cs   = cs_in;
                    s_d.mr   = mr_base;
                    s_d.wlen = wait_len;
                end
            end
            ST_GAP: begin
                s_d.st  = ST_ISSUE;
                s_d.vld = 1'b1;
                s_d.op  = look.op;
            end
            ST_ISSUE: begin
                if (s_q.step == LAST_STEP) begin
                    s_d.st   = ST_DONE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.step = look_idx;
                    if (look.is_wait) begin
                        s_d.st  = ST_WAIT;
                        s_d.cnt = s_q.wlen - 1'b1;
                    end else begin
                        s_d.st   = ST_GAP;
                        s_d.mode = pick_mode(look.msel, s_q.mr, s_q.mode);
                    end
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.step = look_idx;
                    s_d.st   = ST_GAP;
                    s_d.mode = pick_mode(look.msel, s_q.mr, s_q.mode);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_valid = s_q.vld;
    assign cmd_op    = s_q.op;
    assign mode_val  = s_q.mode;
    assign cs_field  = s_q.cs;
    assign done      = s_q.done;

endmodule

// File: rtl/ddr2_bringup_chk.sv
module ddr2_bringup_chk
    import ddr2_init_pkg::*;
#(
    parameter int CS_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [MODE_W-1:0] mode_val,
    input logic [CS_W-1:0]   cs_field,
    input logic              done
);

    logic prev_rst;
    always_ff @(posedge clk) prev_rst <= rst;

    assert_op_legal_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op >= OP_CLR_PD && cmd_op <= OP_AREF));

    assert_op_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_op == OP_NOP));

    assert_no_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_emr_form_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_EMRS) |-> (mode_val[10] && !mode_val[0]));

    assert_cas_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_MRS) |->
        (mode_val[6:4] == 3'd2 || mode_val[6:4] == 3'd3 || mode_val[6:4] == 3'd4));

    assert_cs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $stable(cs_field));

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_MRS || cmd_op == OP_EMRS)) |-> $stable(mode_val));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (!cmd_valid && !done));

endmodule

bind ddr2_bringup_seq ddr2_bringup_chk #(.CS_W(CS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .mode_val  (mode_val),
    .cs_field  (cs_field),
    .done      (done)
);

// File: tb/tb_ddr2_bringup_seq.sv
module tb_ddr2_bringup_seq;
    import ddr2_init_pkg::*;

    localparam int CS_W  = 4;
    localparam int PLL_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CS_W-1:0]   cs_mask = '0;
    logic [1:0]        rank_qual = '0;
    logic              big_mem = 1'b0;
    logic [2:0]        cas_sel = 3'd3;
    logic [2:0]        wr_sel = 3'd2;
    logic              wide_chan = 1'b1;
    logic [PLL_W-1:0]  pll_div = '0;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [MODE_W-1:0] mode_val;
    logic [CS_W-1:0]   cs_field;
    logic              done;

    always #10 clk = ~clk;

    ddr2_bringup_seq dut (
        .clk(clk), .rst(rst), .start(start), .cs_mask(cs_mask),
        .rank_qual(rank_qual), .big_mem(big_mem), .cas_sel(cas_sel),
        .wr_sel(wr_sel), .wide_chan(wide_chan), .pll_div(pll_div),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .mode_val(mode_val),
        .cs_field(cs_field), .done(done)
    );

    typedef struct {
        logic [2:0]        op;
        logic              has_mode;
        logic [MODE_W-1:0] mode;
        logic [CS_W-1:0]   cs;
        int                gap;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int last_cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int done_seen = 0;
    int strobes_seen = 0;
    logic [MODE_W-1:0] prev_mode = '0;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (cmd_valid) begin
                strobes_seen++;
                if (q.size() == 0) begin
                    chk(1'b0, "R11", "strobe with nothing expected", longint'(cmd_op), 0);
                end else begin
                    e = q.pop_front();
                    chk(cmd_op == e.op, "R1", "opcode", longint'(cmd_op), longint'(e.op));
                    if (e.gap == 2)
                        chk(cyc - last_cyc == e.gap, "R3", "strobe spacing",
                            longint'(cyc - last_cyc), longint'(e.gap));
                    else
                        chk(cyc - last_cyc == e.gap, "R2", "spacing after wait",
                            longint'(cyc - last_cyc), longint'(e.gap));
                    chk(cs_field == e.cs, "R9", "cs field", longint'(cs_field), longint'(e.cs));
                    if (e.has_mode) begin
                        if (e.op == OP_MRS)
                            chk(mode_val == e.mode, "R4/R6/R7/R8", "mode word",
                                longint'(mode_val), longint'(e.mode));
                        else
                            chk(mode_val == e.mode, "R5", "extended mode word",
                                longint'(mode_val), longint'(e.mode));
                        chk(prev_mode == mode_val, "R10", "mode held before strobe",
                            longint'(prev_mode), longint'(mode_val));
                    end
                    last_cyc = cyc;
                end
            end
            if (done) begin
                done_seen++;
                chk(q.size() == 0, "R11", "done with strobes pending", longint'(q.size()), 0);
                chk(cyc - last_cyc == 1, "R11", "done timing",
                    longint'(cyc - last_cyc), 1);
            end
        end
        prev_mode = mode_val;
    end

    function automatic int calc_wait(input int div);
        int d;
        int n;
        d = (div == 0) ? 6 : div;
        n = 400000 / ((100 * d) / 2);
        if (n < 1) n = 1;
        return n;
    endfunction

    task automatic push(input logic [2:0] op, input logic hm,
                        input logic [MODE_W-1:0] m, input logic [CS_W-1:0] c, input int g);
        exp_t e;
        e.op = op; e.has_mode = hm; e.mode = m; e.cs = c; e.gap = g;
        q.push_back(e);
    endtask

    task automatic load_expect(input logic [CS_W-1:0] c, input logic [1:0] rq, input logic bm,
                               input logic [2:0] cas, input logic [2:0] wr, input logic wide,
                               input int div);
        int n;
        logic [2:0] cas_e, wr_e, bl_e;
        logic [MODE_W-1:0] mr;
        logic [CS_W-1:0] cx;
        n = calc_wait(div);
        cas_e = (cas == 3'd2 || cas == 3'd3 || cas == 3'd4) ? cas : 3'd3;
        wr_e  = (wr == 3'd4) ? 3'b011 : (wr == 3'd3) ? 3'b010 : 3'b001;
        bl_e  = wide ? 3'b010 : 3'b011;
        mr    = {1'b0, wr_e, 1'b0, 1'b0, cas_e, 1'b0, bl_e};
        cx    = bm ? (c | {rq, 2'b00}) : c;
        push(OP_CLR_PD,  1'b0, '0,             cx, 2);
        push(OP_PRE_ALL, 1'b0, '0,             cx, n + 2);
        push(OP_EMRS,    1'b1, 13'h0400,       cx, 2);
        push(OP_MRS,     1'b1, mr | 13'h0100,  cx, 2);
        push(OP_PRE_ALL, 1'b0, '0,             cx, n + 2);
        push(OP_AREF,    1'b0, '0,             cx, 2);
        push(OP_AREF,    1'b0, '0,             cx, 2);
        push(OP_MRS,     1'b1, mr,             cx, 2);
        push(OP_EMRS,    1'b1, 13'h0780,       cx, 2);
        push(OP_EMRS,    1'b1, 13'h0400,       cx, 2);
    endtask

    task automatic drive_start(input logic [CS_W-1:0] c, input logic [1:0] rq, input logic bm,
                               input logic [2:0] cas, input logic [2:0] wr, input logic wide,
                               input int div);
        @(negedge clk);
        cs_mask = c; rank_qual = rq; big_mem = bm; cas_sel = cas;
        wr_sel = wr; wide_chan = wide; pll_div = PLL_W'(div);
        start = 1'b1;
        last_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int d0;
        d0 = done_seen;
        while (done_seen == d0) @(negedge clk);
    endtask

    task automatic run_seq(input logic [CS_W-1:0] c, input logic [1:0] rq, input logic bm,
                           input logic [2:0] cas, input logic [2:0] wr, input logic wide,
                           input int div, input bit poke);
        int s0;
        load_expect(c, rq, bm, cas, wr, wide, div);
        drive_start(c, rq, bm, cas, wr, wide, div);
        if (poke) begin
            repeat (3) @(negedge clk);
            // R11: start during a series with different inputs is ignored
            cs_mask = 4'hF; big_mem = 1'b0; cas_sel = 3'd2; pll_div = PLL_W'(1);
            wide_chan = ~wide; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        s0 = strobes_seen;
        repeat (12) @(negedge clk);
        chk(strobes_seen == s0, "R11", "idle after done",
            longint'(strobes_seen - s0), 0);
        chk(done == 1'b0, "R11", "done low when idle", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: state during reset
        chk(cmd_valid == 1'b0, "R12", "strobe in reset", longint'(cmd_valid), 0);
        chk(done == 1'b0, "R12", "done in reset", longint'(done), 0);
        chk(cmd_op == 3'd0, "R12", "opcode in reset", longint'(cmd_op), 0);
        chk(mode_val == '0, "R12", "mode in reset", longint'(mode_val), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b0 && done == 1'b0, "R12", "idle after reset",
            longint'({cmd_valid, done}), 0);

        // R1 R2 R7 wide channel, divider 16
        run_seq(4'b0001, 2'd0, 1'b0, 3'd3, 3'd3, 1'b1, 16, 1'b0);
        // R2 divider 0 uses 6; R9 big memory merge; R7 narrow channel; R8 WR4
        run_seq(4'b0010, 2'd2, 1'b1, 3'd4, 3'd4, 1'b0, 0, 1'b0);
        // R6 illegal CAS falls back; R8 other WR falls back; R9 qualifier unused
        run_seq(4'b0100, 2'd3, 1'b0, 3'd5, 3'd7, 1'b1, 31, 1'b0);
        // R11 ignored start during run; R6 CAS 2
        run_seq(4'b1000, 2'd1, 1'b1, 3'd2, 3'd2, 1'b0, 20, 1'b1);

        // R12 reset in the middle of a series
        load_expect(4'b0011, 2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 25);
        drive_start(4'b0011, 2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 25);
        repeat (8) @(negedge clk);
        rst = 1'b1;
        q.delete();
        @(negedge clk);
        chk(cmd_valid == 1'b0 && done == 1'b0, "R12", "outputs during mid-run reset",
            longint'({cmd_valid, done}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b0 && done == 1'b0, "R12", "idle after mid-run reset",
            longint'({cmd_valid, done}), 0);
        begin
            int s1;
            s1 = strobes_seen;
            repeat (400) @(negedge clk);
            chk(strobes_seen == s1, "R12", "no strobes after mid-run reset",
                longint'(strobes_seen - s1), 0);
        end
        // recovery with CAS/WR fallbacks, divider 25
        run_seq(4'b0011, 2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 25, 1'b0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule